// File: doc/BRIEF.md
# Mailbox Command Word Writer

This block delivers a command frame of 16-bit words into a word-addressed command mailbox that sits on a simple slave write port. The receiving processor treats the word at byte offset 0 as the signal that a new command is present. The writer therefore puts down every other word of the frame first and writes that header word last. A pause follows every write, so the slow receiver can absorb each word before the next one arrives. The pause length is programmable in clock cycles and is sampled when a frame is accepted.

Two frame shapes are built inside the block. The first is a bus control message of fixed length. It holds a header, a length pair, a burst code and up to ten payload bytes. A longer requested length is clamped to ten bytes. The second is a two-word tone command whose header selects tone on or tone off. A single-cycle `start` pulse on an idle block latches all inputs, and `busy` stays high until the pause after the header write has run out.

Top module: `mbx_cmd_writer`

## Requirements
- R1: A control message is 18 words. Words with index 2 to 17 are written first, in ascending order. Each goes to byte address 2 x index.
- R2: After the payload words, word 1 is written at address 2. Word 0, the header, is written last at address 0.
- R3: The control-message header is {cmd_type, opcode}, with the type in bits 15:8.
- R4: With c = min(msg_len, 10), word 1 of a control message holds c + 2 and word 2 holds c.
- R5: Word 3 carries the burst code, which depends on burst_sel. A value of 1 (burst A) gives 0x0000 and 2 (burst B) gives 0x0001. A value of 0 or 3 (no burst) gives 0xFFFF.
- R6: Word 4 + i holds {8'h00, msg_bytes[8i+7:8i]} for i < c. Every other word from 4 to 17 is 0.
- R7: When frame_kind is 1, a two-word tone frame is sent. Word 1 is 0 and is written at address 2. The header at address 0 follows it as {cmd_type, 8'h01} when tone_on is 1, or {cmd_type, 8'h02} when tone_on is 0.
- R8: Every write is a one-cycle wr_en pulse. It is followed by max(1, settle_cycles) cycles without a write, so successive writes are 1 + max(1, settle_cycles) cycles apart.
- R9: busy rises in the cycle after an accepted start, and the first write occurs in that same cycle. busy stays high for exactly N x (1 + max(1, settle_cycles)) cycles for an N-word frame.
- R10: A start pulse while busy is ignored. Input changes after acceptance have no effect on the frame being sent.
- R11: After reset, busy and wr_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send a frame; accepted only while idle |
| frame_kind | input | 1 | 0 = control message, 1 = tone command |
| cmd_type | input | 8 | Command type, upper byte of the header |
| opcode | input | 8 | Opcode of a control message, lower byte of the header |
| tone_on | input | 1 | Tone frame selects on (1) or off (0) |
| msg_len | input | 8 | Requested payload length in bytes, clamped to 10 |
| msg_bytes | input | 80 | Payload bytes, byte i in bits 8i+7:8i |
| burst_sel | input | 2 | Burst selection: 1 = A, 2 = B, 0/3 = none |
| settle_cycles | input | 16 | Pause after each write, in cycles (0 acts as 1) |
| busy | output | 1 | Frame in progress |
| wr_en | output | 1 | Mailbox write strobe |
| wr_addr | output | 6 | Mailbox byte address |
| wr_data | output | 16 | Mailbox write data |

## Verification
A corrupted word index shows up at the ports within one write period. The fault appears either as an address out of the expected payload-then-length-then-header order or as data belonging to a different frame slot. A miscounting pause timer changes the spacing between two write strobes, which shows on the very next write. It also changes the total busy length, which shows by the end of the frame. Latched inputs that are not held would show a changed payload or header after a mid-frame start pulse, on the first write that follows the pulse.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_WAIT  = 2'd2
  } phase_t;

  // burst selection to the 16-bit burst word
  function automatic logic [15:0] burst_word(input logic [1:0] sel);
    case (sel)
      2'd1:    return 16'h0000;
      2'd2:    return 16'h0001;
      default: return 16'hFFFF;
    endcase
  endfunction

  // first word index written for a frame of n words
  function automatic int first_index(input int n);
    return (n > 2) ? 2 : 1;
  endfunction

  // index written after idx: ascending payload, then word 1, then header
  function automatic int next_index(input int idx, input int n);
    if (idx >= 2 && idx < n - 1) return idx + 1;
    else if (idx >= 2)           return 1;
    else                         return 0;
  endfunction

  // pause length actually applied
  function automatic int settle_len(input int s);
    return (s < 1) ? 1 : s;
  endfunction

endpackage

// File: rtl/mbx_settle_timer.sv
module mbx_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (load_val == '0) ? CNT_W'(1) : load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign last = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/mbx_write_sequencer.sv
module mbx_write_sequencer
  import mbx_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [IDX_W:0] nwords,
  input  logic           tmr_last,
  output logic           accept,
  output logic           busy,
  output logic           wr_en,
  output logic [IDX_W-1:0] idx,
  output logic [IDX_W-1:0] prev_idx
);
  phase_t           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] prev_q;
  logic [IDX_W:0]   nw_q;

  assign accept   = start && (phase_q == PH_IDLE);
  assign busy     = (phase_q != PH_IDLE);
  assign wr_en    = (phase_q == PH_WRITE);
  assign idx      = idx_q;
  assign prev_idx = prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      idx_q   <= '0;
      prev_q  <= '0;
      nw_q    <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_WRITE;
            nw_q    <= nwords;
            idx_q   <= IDX_W'(first_index(int'(nwords)));
          end
        end
        PH_WRITE: begin
          phase_q <= PH_WAIT;
          prev_q  <= idx_q;
        end
        PH_WAIT: begin
          if (tmr_last) begin
            if (idx_q == '0) begin
              phase_q <= PH_IDLE;
            end else begin
              phase_q <= PH_WRITE;
              idx_q   <= IDX_W'(next_index(int'(idx_q), int'(nw_q)));
            end
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R8: a strobe never lasts two cycles
  assert_write_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R9: accepted start leads to busy and the first write next cycle
  assert_first_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && wr_en));

  // R2: header write directly follows the word-1 write
  assert_header_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == '0) |-> (prev_idx == IDX_W'(1)));

  // R1: payload words go out in ascending order
  assert_ascending_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx > IDX_W'(2)) |-> (prev_idx == idx - IDX_W'(1)));

endmodule

// File: rtl/mbx_frame_packer.sv
module mbx_frame_packer
  import mbx_pkg::*;
#(
  parameter int         MAX_PAYLOAD = 10,
  parameter int         LEN_W       = 8,
  parameter int         IDX_W       = 5,
  parameter logic [7:0] TONE_ON_OP  = 8'h01,
  parameter logic [7:0] TONE_OFF_OP = 8'h02
) (
  input  logic                     kind_tone,
  input  logic [7:0]               cmd_type,
  input  logic [7:0]               opcode,
  input  logic                     tone_on,
  input  logic [LEN_W-1:0]         len,
  input  logic [MAX_PAYLOAD*8-1:0] bytes,
  input  logic [1:0]               burst_sel,
  input  logic [IDX_W-1:0]         idx,
  output logic [15:0]              word
);
  logic [LEN_W-1:0] clen;
  logic [15:0]      pay_word [MAX_PAYLOAD];

  assign clen = (len > LEN_W'(MAX_PAYLOAD)) ? LEN_W'(MAX_PAYLOAD) : len;

  for (genvar g = 0; g < MAX_PAYLOAD; g++) begin : g_pay
    assign pay_word[g] = (LEN_W'(g) < clen) ? {8'h00, bytes[g*8 +: 8]} : 16'h0000;
  end

  always_comb begin
    word = 16'h0000;
    if (kind_tone) begin
      if (idx == '0) word = {cmd_type, tone_on ? TONE_ON_OP : TONE_OFF_OP};
    end else begin
      if (idx == IDX_W'(0))      word = {cmd_type, opcode};
      else if (idx == IDX_W'(1)) word = 16'(clen) + 16'd2;
      else if (idx == IDX_W'(2)) word = 16'(clen);
      else if (idx == IDX_W'(3)) word = burst_word(burst_sel);
      for (int i = 0; i < MAX_PAYLOAD; i++) begin
        if (idx == IDX_W'(i + 4)) word = pay_word[i];
      end
    end
  end

endmodule

// File: rtl/mbx_cmd_writer.sv
module mbx_cmd_writer
  import mbx_pkg::*;
#(
  parameter int         FRAME_WORDS = 18,
  parameter int         MAX_PAYLOAD = 10,
  parameter int         LEN_W       = 8,
  parameter int         CNT_W       = 16,
  parameter logic [7:0] TONE_ON_OP  = 8'h01,
  parameter logic [7:0] TONE_OFF_OP = 8'h02
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     frame_kind,
  input  logic [7:0]               cmd_type,
  input  logic [7:0]               opcode,
  input  logic                     tone_on,
  input  logic [LEN_W-1:0]         msg_len,
  input  logic [MAX_PAYLOAD*8-1:0] msg_bytes,
  input  logic [1:0]               burst_sel,
  input  logic [CNT_W-1:0]         settle_cycles,
  output logic                     busy,
  output logic                     wr_en,
  output logic [$clog2(FRAME_WORDS):0] wr_addr,
  output logic [15:0]              wr_data
);
  localparam int IDX_W = $clog2(FRAME_WORDS);

  logic                     lat_kind;
  logic [7:0]               lat_type;
  logic [7:0]               lat_op;
  logic                     lat_tone_on;
  logic [LEN_W-1:0]         lat_len;
  logic [MAX_PAYLOAD*8-1:0] lat_bytes;
  logic [1:0]               lat_burst;
  logic [CNT_W-1:0]         lat_settle;

  logic                     accept;
  logic                     tmr_last;
  logic [IDX_W-1:0]         cur_idx;
  logic [IDX_W-1:0]         prev_idx;
  logic [IDX_W:0]           frame_len;

  assign frame_len = frame_kind ? (IDX_W+1)'(2) : (IDX_W+1)'(FRAME_WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_kind    <= 1'b0;
      lat_type    <= '0;
      lat_op      <= '0;
      lat_tone_on <= 1'b0;
      lat_len     <= '0;
      lat_bytes   <= '0;
      lat_burst   <= '0;
      lat_settle  <= '0;
    end else if (accept) begin
      lat_kind    <= frame_kind;
      lat_type    <= cmd_type;
      lat_op      <= opcode;
      lat_tone_on <= tone_on;
      lat_len     <= msg_len;
      lat_bytes   <= msg_bytes;
      lat_burst   <= burst_sel;
      lat_settle  <= settle_cycles;
    end
  end

  mbx_write_sequencer #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .nwords   (frame_len),
    .tmr_last (tmr_last),
    .accept   (accept),
    .busy     (busy),
    .wr_en    (wr_en),
    .idx      (cur_idx),
    .prev_idx (prev_idx)
  );

  mbx_settle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_en),
    .load_val (lat_settle),
    .last     (tmr_last)
  );

  mbx_frame_packer #(
    .MAX_PAYLOAD (MAX_PAYLOAD),
    .LEN_W       (LEN_W),
    .IDX_W       (IDX_W),
    .TONE_ON_OP  (TONE_ON_OP),
    .TONE_OFF_OP (TONE_OFF_OP)
  ) u_pack (
    .kind_tone (lat_kind),
    .cmd_type  (lat_type),
    .opcode    (lat_op),
    .tone_on   (lat_tone_on),
    .len       (lat_len),
    .bytes     (lat_bytes),
    .burst_sel (lat_burst),
    .idx       (cur_idx),
    .word      (wr_data)
  );

  assign wr_addr = {cur_idx, 1'b0};

  // R10: captured frame inputs hold for the whole frame
  assert_fields_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(lat_bytes) && $stable(lat_len) && $stable(lat_kind) && $stable(lat_settle)));

  // R9: no write strobe outside a frame
  assert_no_idle_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

endmodule

// File: tb/mbx_cmd_writer_tb_top.sv
`timescale 1ns/1ps
module mbx_cmd_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        frame_kind = 1'b0;
  logic [7:0]  cmd_type = '0;
  logic [7:0]  opcode = '0;
  logic        tone_on = 1'b0;
  logic [7:0]  msg_len = '0;
  logic [79:0] msg_bytes = '0;
  logic [1:0]  burst_sel = '0;
  logic [15:0] settle_cycles = '0;
  logic        busy, wr_en;
  logic [5:0]  wr_addr;
  logic [15:0] wr_data;

  always #2.5 clk = ~clk;

  mbx_cmd_writer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .frame_kind(frame_kind),
    .cmd_type(cmd_type), .opcode(opcode), .tone_on(tone_on), .msg_len(msg_len),
    .msg_bytes(msg_bytes), .burst_sel(burst_sel), .settle_cycles(settle_cycles),
    .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_vec = 0, n_bad = 0, cyc = 0, n_wr = 0, busy_cnt = 0;
  bit cap = 1'b0, finished = 1'b0;
  logic [5:0]  wa [32];
  logic [15:0] wd [32];
  int          wt [32];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!cap) begin
      n_wr = 0; busy_cnt = 0;
    end else begin
      if (wr_en) begin
        if (n_wr < 32) begin wa[n_wr] = wr_addr; wd[n_wr] = wr_data; wt[n_wr] = cyc; end
        n_wr = n_wr + 1;
      end
      if (busy) busy_cnt = busy_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input bit tone, input int idx, input logic [7:0] ty,
      input logic [7:0] op, input bit ton, input int len, input logic [79:0] b, input logic [1:0] bs);
    int c;
    c = (len > 10) ? 10 : len;
    if (tone) return (idx == 0) ? {ty, (ton ? 8'h01 : 8'h02)} : 16'h0000;
    if (idx == 0) return {ty, op};
    if (idx == 1) return 16'(c + 2);
    if (idx == 2) return 16'(c);
    if (idx == 3) return (bs == 2'd1) ? 16'h0000 : ((bs == 2'd2) ? 16'h0001 : 16'hFFFF);
    if (idx - 4 < c) return {8'h00, b[(idx-4)*8 +: 8]};
    return 16'h0000;
  endfunction

  task automatic run_frame(input bit tone, input logic [7:0] ty, input logic [7:0] op, input bit ton,
      input int len, input logic [79:0] b, input logic [1:0] bs, input int s, input bit disturb);
    int n, gap, idx;
    string dtag;
    cap = 1'b0;
    @(negedge clk); @(negedge clk);
    cap = 1'b1;
    frame_kind = tone; cmd_type = ty; opcode = op; tone_on = ton; msg_len = 8'(len);
    msg_bytes = b; burst_sel = bs; settle_cycles = 16'(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      repeat (6) @(negedge clk);
      frame_kind = ~tone; cmd_type = ~ty; opcode = ~op; msg_len = 8'(len + 3);
      msg_bytes = ~b; burst_sel = ~bs; settle_cycles = 16'(s + 4); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (busy) @(negedge clk);
    n = tone ? 2 : 18;
    gap = 1 + ((s < 1) ? 1 : s);
    chk(n_wr == n, tone ? "R7 count" : "R1 count", n_wr, n);
    for (int k = 0; k < n && k < n_wr; k++) begin
      idx = (k < n - 2) ? k + 2 : ((k == n - 2) ? 1 : 0);
      dtag = disturb ? "R10" : (tone ? "R7" : (idx == 0 ? "R3" : (idx < 3 ? "R4" : (idx == 3 ? "R5" : "R6"))));
      chk(wa[k] == 6'(2 * idx), disturb ? "R10 addr" : (idx >= 2 ? "R1 addr" : "R2 addr"), wa[k], 2 * idx);
      chk(wd[k] == exp_word(tone, idx, ty, op, ton, len, b, bs), dtag, wd[k],
          exp_word(tone, idx, ty, op, ton, len, b, bs));
      if (k > 0) chk(wt[k] - wt[k-1] == gap, "R8 spacing", wt[k] - wt[k-1], gap);
    end
    chk(busy_cnt == n * gap, "R9 busy length", busy_cnt, n * gap);
  endtask

  function automatic logic [79:0] pat(input int seed);
    logic [79:0] r;
    for (int i = 0; i < 10; i++) r[i*8 +: 8] = 8'((seed * 37 + i * 91 + 128) & 255);
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R11 busy", busy, 0);
    chk(wr_en == 1'b0, "R11 wr_en", wr_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && wr_en == 1'b0, "R11 after release", {busy, wr_en}, 0);
    for (int len = 0; len <= 12; len++)
      for (int bs = 0; bs < 4; bs++)
        run_frame(1'b0, 8'(8'h30 + len), 8'(8'hA0 + bs), 1'b0, len, pat(len * 4 + bs), 2'(bs), 1, 1'b0);
    run_frame(1'b0, 8'h5A, 8'hC3, 1'b0, 7, pat(99), 2'd2, 0, 1'b0);
    run_frame(1'b0, 8'hE1, 8'h1E, 1'b0, 255, pat(7), 2'd1, 5, 1'b0);
    run_frame(1'b1, 8'h42, 8'h00, 1'b1, 0, '0, 2'd0, 2, 1'b0);
    run_frame(1'b1, 8'h42, 8'h00, 1'b0, 0, '0, 2'd0, 0, 1'b0);
    run_frame(1'b0, 8'h77, 8'h88, 1'b0, 5, pat(3), 2'd2, 2, 1'b1);
    run_frame(1'b1, 8'h19, 8'h00, 1'b1, 0, '0, 2'd0, 3, 1'b1);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule